// File: doc/BRIEF.md
# Decimal-Capable Accumulator Adder/Subtractor

This block is the arithmetic core behind an accumulator's add-with-carry and subtract-with-borrow operations. Each operation carries its own controls: add or subtract, binary or packed-BCD, and 8-bit or 16-bit width. The block takes the accumulator value, the memory operand and the incoming carry flag, and it produces the new accumulator value together with carry, overflow, zero and negative flags.

In decimal mode the correction works digit by digit. Addition ripples a decimal carry upward one nibble at a time. Subtraction first takes every raw nibble difference and then runs a borrow fix-up from the lowest nibble to the highest. In both modes overflow is judged on the corrected decimal result, not on the raw binary sum.

Outputs are captured one clock after a valid strobe and then held until the next strobe. Instruction decode, addressing and memory access are handled elsewhere.

Top module: `accum_arith_unit`

## Requirements
- R1: When `in_valid` is high on a rising edge, `result` and all flags update on that edge and `out_valid` is high for the following cycle. When `in_valid` is low, `out_valid` goes low and `result` and the flags hold their values.
- R2: While `rst_n` is low, `out_valid`, `result`, `carry_out`, `ovf_out`, `zero_out` and `neg_out` are all 0.
- R3: Binary add (`dec_mode`=0, `op_sub`=0) produces accumulator + operand + `carry_in` at the active width. `carry_out` is 1 when the sum exceeds 0xFF in 8-bit mode (`wide`=0) or 0xFFFF in 16-bit mode (`wide`=1).
- R4: Binary subtract (`op_sub`=1) produces accumulator + ~operand + `carry_in` at the active width. `carry_out`=1 means no borrow occurred.
- R5: Decimal add (`dec_mode`=1) works on nibbles from lowest to highest. Each nibble sum is accumulator digit + operand digit + incoming link, where the link into nibble 0 is `carry_in`. A sum above 9 has 10 removed, keeps its low 4 bits and passes a 1 to the next nibble. The link out of the top active nibble becomes `carry_out`.
- R6: Decimal subtract computes each raw nibble difference with 8-bit wraparound. The borrow into nibble 0 is the inverse of `carry_in`. Then, from low to high, a value above 9 (including a wrapped negative) has 10 added, keeps its low 4 bits and takes 1 from the next nibble. `carry_out` is the inverse of the borrow out of the top active nibble.
- R7: For an add, `ovf_out` is 1 exactly when the accumulator and operand sign bits are equal and the result sign bit differs from them. In decimal mode the corrected result is used, so 0x50+0x50 gives 0x00 with no overflow.
- R8: For a subtract, `ovf_out` is 1 exactly when the accumulator and operand sign bits differ and the accumulator and result sign bits differ.
- R9: `zero_out` is 1 when the result is 0 at the active width. `neg_out` is the result sign bit: bit 7 in 8-bit mode, bit 15 in 16-bit mode.
- R10: In 8-bit mode, `result[15:8]` equals `acc_in[15:8]` and `opnd_in[15:8]` has no effect.
- R11: Non-decimal digit inputs are corrected without disturbing their neighbours except through the link. An 8-bit decimal add of 0x0F+0x00 with carry in 0 gives 0x15 with carry 0. An 8-bit decimal subtract of 0x0F−0x00 with carry in 1 gives 0x99 with carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| acc_in | input | 16 | Accumulator value |
| opnd_in | input | 16 | Memory operand |
| carry_in | input | 1 | Incoming carry flag (1 = no borrow for subtract) |
| dec_mode | input | 1 | 1 = packed-BCD arithmetic |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| out_valid | output | 1 | Result captured last edge |
| result | output | 16 | New accumulator value |
| carry_out | output | 1 | Carry flag |
| ovf_out | output | 1 | Overflow flag |
| zero_out | output | 1 | Zero flag |
| neg_out | output | 1 | Negative flag |

## Verification
Decimal carry or borrow propagation and the overflow judgement can land in the same cycle, because both depend on the corrected top digit. The vector table provokes this with operands whose binary and decimal sign bits disagree. Examples are 0x50+0x50, which carries out with no overflow, and 0x49+0x49 and 0x4000+0x4000, which overflow without carrying. Each vector is judged on result and all four flags together. A second coincidence is a fresh strobe in the cycle right after a capture. Back-to-back strobes check that each result appears exactly one edge after its own strobe.

// File: rtl/accum_arith_pkg.sv
package accum_arith_pkg;

  localparam int NIB_W     = 4;
  localparam int DIGIT_MAX = 9;
  localparam int RADIX     = 10;

  // one corrected digit plus the link (carry or borrow) it hands upward
  typedef struct packed {
    logic [NIB_W-1:0] digit;
    logic             link;
  } digit_res_t;

  // decimal add of one digit: sum above 9 is reduced by 10 and carries
  function automatic digit_res_t dec_add_digit(input logic [NIB_W-1:0] a,
                                               input logic [NIB_W-1:0] b,
                                               input logic             cin);
    digit_res_t       r;
    logic [NIB_W+1:0] s;
    s = {2'b00, a} + {2'b00, b} + {{(NIB_W+1){1'b0}}, cin};
    if (s > (NIB_W+2)'(DIGIT_MAX)) begin
      s      = s - (NIB_W+2)'(RADIX);
      r.link = 1'b1;
    end else begin
      r.link = 1'b0;
    end
    r.digit = s[NIB_W-1:0];
    return r;
  endfunction

  // decimal subtract of one digit: byte-wide wrap, fix-up adds 10 and borrows
  function automatic digit_res_t dec_sub_digit(input logic [NIB_W-1:0] a,
                                               input logic [NIB_W-1:0] b,
                                               input logic             bin);
    digit_res_t r;
    logic [7:0] d;
    d = {4'h0, a} - {4'h0, b} - {7'h00, bin};
    if (d > 8'(DIGIT_MAX)) begin
      d      = d + 8'(RADIX);
      r.link = 1'b1;
    end else begin
      r.link = 1'b0;
    end
    r.digit = d[NIB_W-1:0];
    return r;
  endfunction

  function automatic logic add_overflow(input logic a_s, input logic b_s,
                                        input logic r_s);
    return (a_s == b_s) && (r_s != b_s);
  endfunction

  function automatic logic sub_overflow(input logic a_s, input logic b_s,
                                        input logic r_s);
    return (a_s != b_s) && (a_s != r_s);
  endfunction

endpackage

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
  import accum_arith_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [DATA_W-1:0]       a_i,
  input  logic [DATA_W-1:0]       b_i,
  input  logic                    link_i,
  output logic [DATA_W-1:0]       digits_o,
  output logic [DATA_W/NIB_W:0]   link_o
);
  localparam int NIBBLES = DATA_W / NIB_W;

  if (SUBTRACT) begin : g_sub
    // raw differences first; the fix-up ripple is folded into the link order
    always_comb begin
      digit_res_t r;
      link_o    = '0;
      digits_o  = '0;
      link_o[0] = link_i;
      for (int i = 0; i < NIBBLES; i++) begin
        r = dec_sub_digit(a_i[i*NIB_W +: NIB_W], b_i[i*NIB_W +: NIB_W],
                          link_o[i]);
        digits_o[i*NIB_W +: NIB_W] = r.digit;
        link_o[i+1]                = r.link;
      end
    end
  end else begin : g_add
    always_comb begin
      digit_res_t r;
      link_o    = '0;
      digits_o  = '0;
      link_o[0] = link_i;
      for (int i = 0; i < NIBBLES; i++) begin
        r = dec_add_digit(a_i[i*NIB_W +: NIB_W], b_i[i*NIB_W +: NIB_W],
                          link_o[i]);
        digits_o[i*NIB_W +: NIB_W] = r.digit;
        link_o[i+1]                = r.link;
      end
    end
  end

endmodule

// File: rtl/bin_addsub.sv
module bin_addsub #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_narrow_o,
  output logic              carry_wide_o
);
  logic [DATA_W-1:0]   b_eff;
  logic [DATA_W:0]     full_sum;
  logic [NARROW_W:0]   low_sum;

  always_comb begin
    b_eff          = sub_i ? ~b_i : b_i;
    full_sum       = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_i};
    low_sum        = {1'b0, a_i[NARROW_W-1:0]} + {1'b0, b_eff[NARROW_W-1:0]}
                   + {{NARROW_W{1'b0}}, carry_i};
    sum_o          = full_sum[DATA_W-1:0];
    carry_wide_o   = full_sum[DATA_W];
    carry_narrow_o = low_sum[NARROW_W];
  end

endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import accum_arith_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              wide_i,
  input  logic              sub_i,
  output logic              ovf_o,
  output logic              zero_o,
  output logic              neg_o
);
  logic a_sign, b_sign, r_sign;

  always_comb begin
    a_sign = wide_i ? acc_i[DATA_W-1]  : acc_i[NARROW_W-1];
    b_sign = wide_i ? opnd_i[DATA_W-1] : opnd_i[NARROW_W-1];
    r_sign = wide_i ? res_i[DATA_W-1]  : res_i[NARROW_W-1];
    ovf_o  = sub_i ? sub_overflow(a_sign, b_sign, r_sign)
                   : add_overflow(a_sign, b_sign, r_sign);
    zero_o = wide_i ? (res_i == '0) : (res_i[NARROW_W-1:0] == '0);
    neg_o  = r_sign;
  end

endmodule

// File: rtl/accum_arith_unit.sv
module accum_arith_unit
  import accum_arith_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              carry_in,
  input  logic              dec_mode,
  input  logic              wide,
  input  logic              op_sub,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              ovf_out,
  output logic              zero_out,
  output logic              neg_out
);
  localparam int NIBBLES     = DATA_W / NIB_W;
  localparam int NARROW_NIBS = NARROW_W / NIB_W;

  logic [DATA_W-1:0] dec_add_sum, dec_sub_diff, bin_sum;
  logic [NIBBLES:0]  dec_add_link, dec_sub_link;
  logic              bin_carry_narrow, bin_carry_wide;
  logic [DATA_W-1:0] raw_result, nxt_result;
  logic              nxt_carry, nxt_ovf, nxt_zero, nxt_neg;

  bcd_digit_chain #(.DATA_W(DATA_W), .SUBTRACT(1'b0)) add_chain_i (
    .a_i      (acc_in),
    .b_i      (opnd_in),
    .link_i   (carry_in),
    .digits_o (dec_add_sum),
    .link_o   (dec_add_link)
  );

  bcd_digit_chain #(.DATA_W(DATA_W), .SUBTRACT(1'b1)) sub_chain_i (
    .a_i      (acc_in),
    .b_i      (opnd_in),
    .link_i   (~carry_in),
    .digits_o (dec_sub_diff),
    .link_o   (dec_sub_link)
  );

  bin_addsub #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) bin_i (
    .a_i            (acc_in),
    .b_i            (opnd_in),
    .carry_i        (carry_in),
    .sub_i          (op_sub),
    .sum_o          (bin_sum),
    .carry_narrow_o (bin_carry_narrow),
    .carry_wide_o   (bin_carry_wide)
  );

  always_comb begin
    unique case ({dec_mode, op_sub})
      2'b10: begin
        raw_result = dec_add_sum;
        nxt_carry  = wide ? dec_add_link[NIBBLES] : dec_add_link[NARROW_NIBS];
      end
      2'b11: begin
        raw_result = dec_sub_diff;
        nxt_carry  = wide ? ~dec_sub_link[NIBBLES] : ~dec_sub_link[NARROW_NIBS];
      end
      default: begin
        raw_result = bin_sum;
        nxt_carry  = wide ? bin_carry_wide : bin_carry_narrow;
      end
    endcase
    nxt_result = wide ? raw_result
                      : {acc_in[DATA_W-1:NARROW_W], raw_result[NARROW_W-1:0]};
  end

  flag_gen #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) flags_i (
    .acc_i  (acc_in),
    .opnd_i (opnd_in),
    .res_i  (nxt_result),
    .wide_i (wide),
    .sub_i  (op_sub),
    .ovf_o  (nxt_ovf),
    .zero_o (nxt_zero),
    .neg_o  (nxt_neg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      ovf_out   <= 1'b0;
      zero_out  <= 1'b0;
      neg_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_result;
        carry_out <= nxt_carry;
        ovf_out   <= nxt_ovf;
        zero_out  <= nxt_zero;
        neg_out   <= nxt_neg;
      end
    end
  end

endmodule

// File: rtl/accum_arith_checker.sv
module accum_arith_checker #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] opnd_in,
  input logic              carry_in,
  input logic              dec_mode,
  input logic              wide,
  input logic              op_sub,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              carry_out,
  input logic              ovf_out,
  input logic              zero_out,
  input logic              neg_out
);
  function automatic logic all_digits_ok(input logic [DATA_W-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DATA_W/4; i++)
      if (x[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic a_sign, b_sign;
  assign a_sign = wide ? acc_in[DATA_W-1]  : acc_in[NARROW_W-1];
  assign b_sign = wide ? opnd_in[DATA_W-1] : opnd_in[NARROW_W-1];

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry_out) && $stable(ovf_out)
                   && $stable(zero_out) && $stable(neg_out)));
  assert_bin_add_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_mode && !op_sub && !wide) |=>
      ({carry_out, result[NARROW_W-1:0]} ==
       ({1'b0, $past(acc_in[NARROW_W-1:0])} + {1'b0, $past(opnd_in[NARROW_W-1:0])}
        + {{NARROW_W{1'b0}}, $past(carry_in)})));
  assert_bin_sub_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_mode && op_sub && wide) |=>
      ({carry_out, result} ==
       ({1'b0, $past(acc_in)} + {1'b0, ~$past(opnd_in)}
        + {{DATA_W{1'b0}}, $past(carry_in)})));
  assert_bcd_digits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_mode && wide && all_digits_ok(acc_in) && all_digits_ok(opnd_in))
      |=> all_digits_ok(result));
  assert_sub_zero_opnd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_mode && op_sub && wide && carry_in && opnd_in == '0
     && all_digits_ok(acc_in)) |=> (carry_out && result == $past(acc_in)));
  assert_no_add_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sub && (a_sign != b_sign)) |=> !ovf_out);
  assert_no_sub_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sub && (a_sign == b_sign)) |=> !ovf_out);
  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (zero_out == ($past(wide) ? (result == '0)
                                           : (result[NARROW_W-1:0] == '0))));
  assert_upper_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[DATA_W-1:NARROW_W] == $past(acc_in[DATA_W-1:NARROW_W])));

endmodule

bind accum_arith_unit accum_arith_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in), .opnd_in(opnd_in),
  .carry_in(carry_in), .dec_mode(dec_mode), .wide(wide), .op_sub(op_sub),
  .out_valid(out_valid), .result(result), .carry_out(carry_out), .ovf_out(ovf_out),
  .zero_out(zero_out), .neg_out(neg_out)
);

// File: tb/accum_arith_unit_tb_top.sv
module accum_arith_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] acc_in = '0;
  logic [15:0] opnd_in = '0;
  logic        carry_in = 1'b0, dec_mode = 1'b0, wide = 1'b0, op_sub = 1'b0;
  logic        out_valid;
  logic [15:0] result;
  logic        carry_out, ovf_out, zero_out, neg_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  accum_arith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in), .opnd_in(opnd_in),
    .carry_in(carry_in), .dec_mode(dec_mode), .wide(wide), .op_sub(op_sub),
    .out_valid(out_valid), .result(result), .carry_out(carry_out), .ovf_out(ovf_out),
    .zero_out(zero_out), .neg_out(neg_out)
  );

  // {sub, dec, wide, cin, acc[16], opnd[16], res[16], c, v, z, n}
  localparam int NV = 21;
  localparam bit [55:0] VECS [NV] = '{
    {4'b0000, 16'h1234, 16'hAB56, 16'h128A, 4'b0101},  // 0  R3 binary add narrow, V set
    {4'b0000, 16'h00FF, 16'h0001, 16'h0000, 4'b1010},  // 1  R3 carry, R9 zero
    {4'b0011, 16'h7FFF, 16'h0000, 16'h8000, 4'b0101},  // 2  R3 wide, carry in
    {4'b0011, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'b1001},  // 3  R3 wide carry
    {4'b1001, 16'hAA50, 16'h0030, 16'hAA20, 4'b1000},  // 4  R4 no borrow
    {4'b1001, 16'h0010, 16'h0020, 16'h00F0, 4'b0001},  // 5  R4 borrow
    {4'b1011, 16'h8000, 16'h0001, 16'h7FFF, 4'b1100},  // 6  R8 sub overflow
    {4'b1010, 16'h1234, 16'h1234, 16'hFFFF, 4'b0001},  // 7  R4 borrow in
    {4'b0100, 16'h0050, 16'h0050, 16'h0000, 4'b1010},  // 8  R7 decimal carry, no V
    {4'b0100, 16'h0049, 16'h0049, 16'h0098, 4'b0101},  // 9  R7 decimal V
    {4'b0111, 16'h9999, 16'h0000, 16'h0000, 4'b1010},  // 10 R5 full ripple
    {4'b0110, 16'h1234, 16'h5678, 16'h6912, 4'b0000},  // 11 R5 wide
    {4'b1101, 16'h0046, 16'h0012, 16'h0034, 4'b1000},  // 12 R6 simple
    {4'b1101, 16'h0012, 16'h0034, 16'h0078, 4'b0000},  // 13 R6 borrow out
    {4'b1111, 16'h1000, 16'h0001, 16'h0999, 4'b1000},  // 14 R6 borrow ripple
    {4'b1110, 16'h0000, 16'h0000, 16'h9999, 4'b0001},  // 15 R6 borrow in
    {4'b1101, 16'h0080, 16'h0010, 16'h0070, 4'b1100},  // 16 R8 decimal V
    {4'b0100, 16'h000F, 16'h0000, 16'h0015, 4'b0000},  // 17 R11 add invalid digit
    {4'b1101, 16'h000F, 16'h0000, 16'h0099, 4'b0001},  // 18 R11 sub invalid digit
    {4'b0101, 16'hC312, 16'hFF07, 16'hC320, 4'b0000},  // 19 R10 upper ignored
    {4'b0110, 16'h4000, 16'h4000, 16'h8000, 4'b0101}   // 20 R7 wide decimal V
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 2, 3:       return "R3";
      1:             return "R3/R9";
      4, 5, 7:       return "R4";
      6, 16:         return "R8";
      8:             return "R7/R9";
      9, 20:         return "R7";
      10:            return "R5/R9";
      11:            return "R5";
      12, 13, 14, 15: return "R6";
      17, 18:        return "R11";
      default:       return "R10";
    endcase
  endfunction

  task automatic check_out(input string req, input logic [15:0] e_res,
                           input logic [3:0] e_flags, input logic e_vld);
    n_checks++;
    if (result !== e_res || {carry_out, ovf_out, zero_out, neg_out} !== e_flags
        || out_valid !== e_vld) begin
      n_fail++;
      $display("FAIL %s: got res=%h cvzn=%b vld=%b, expected res=%h cvzn=%b vld=%b",
               req, result, {carry_out, ovf_out, zero_out, neg_out}, out_valid,
               e_res, e_flags, e_vld);
    end
  endtask

  task automatic drive(input bit [55:0] v);
    {op_sub, dec_mode, wide, carry_in} = v[55:52];
    acc_in  = v[51:36];
    opnd_in = v[35:20];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check_out("R2", 16'h0000, 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R2", 16'h0000, 4'b0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_out(vec_req(i), VECS[i][19:4], VECS[i][3:0], 1'b1);
    end

    // R1: with no strobe the last result holds and out_valid drops
    drive({4'b0011, 16'h0001, 16'h0001, 16'h0000, 4'b0000});
    @(negedge clk);
    check_out("R1", VECS[NV-1][19:4], VECS[NV-1][3:0], 1'b0);
    @(negedge clk);
    check_out("R1", VECS[NV-1][19:4], VECS[NV-1][3:0], 1'b0);

    // R1: back-to-back strobes, each result one edge after its strobe
    drive(VECS[9]);
    in_valid = 1'b1;
    @(negedge clk);
    check_out("R1", VECS[9][19:4], VECS[9][3:0], 1'b1);
    drive(VECS[14]);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R1", VECS[14][19:4], VECS[14][3:0], 1'b1);

    // R10: upper operand byte alone changed gives the same narrow result
    drive(VECS[19]);
    opnd_in[15:8] = 8'h00;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R10", VECS[19][19:4], VECS[19][3:0], 1'b1);

    // R2: reset in mid-run clears captured values
    rst_n = 1'b0;
    @(negedge clk);
    check_out("R2", 16'h0000, 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule